// File: doc/BRIEF.md
# Size-Aware Byte-Lane Memory Port

A memory-side adapter in front of a small word-organised RAM for a 32-bit core. The core issues byte, halfword and word loads and stores with a byte address, a size code, write data and a write strobe. The core's strobe is size-shaped: it is not shifted by the address, so it cannot be used as a lane mask. The port ignores it. It derives the byte lanes that a store touches from the size code and the two low address bits. Store data is replicated across the lanes, so the low byte or halfword of the write data lands in whichever lane the mask picks.

On a load the port reads the addressed word and moves the addressed byte or halfword down into the low bits of the read data. It fills the upper bits with zero. Sign extension is left to the core. Read data comes back one cycle after the request and is marked by a valid output.

Accesses whose address does not suit their size raise a fault for one cycle. A faulting access leaves memory unchanged and produces no read response. The RAM size is set by the byte-address width parameter. The default is a 4 KiB array, and a width of 24 gives 16 MiB.

Top module: `lane_mem_port`

## Requirements
- R1: While rst_ni is low, rd_valid_o, misalign_o and rd_data_o are all 0.
- R2: A read request (req_rd_i=1, req_wr_i=0) that is aligned raises rd_valid_o for exactly the following cycle. A cycle with no request leaves rd_valid_o low in the following cycle.
- R3: For a byte read (size code 2'b00), the byte at byte offset addr[1:0] of the addressed word appears in rd_data_o[7:0]. Byte lane k holds bits 8k+7..8k, and rd_data_o[31:8] is 0.
- R4: For a halfword read (size code 2'b01), bits 31..16 of the word appear in rd_data_o[15:0] when addr[1]=1, and bits 15..0 appear there when addr[1]=0. rd_data_o[31:16] is 0.
- R5: For a word read (size code 2'b10), the whole word appears in rd_data_o. Size code 2'b11 behaves as a word access for reads, writes and alignment.
- R6: A store writes only the lanes given by size and addr[1:0]: lane addr[1:0] for a byte, lanes 1..0 or 3..2 for a halfword (chosen by addr[1]), and all four lanes for a word. A byte store writes req_wdata_i[7:0] and a halfword store writes req_wdata_i[15:0].
- R7: req_strb_i has no effect. Any strobe value, including 4'b0000 and values that disagree with the size, gives the same memory contents.
- R8: A halfword access is misaligned only when addr[0]=1. A halfword at byte offset 2 is legal.
- R9: A word access is misaligned whenever addr[1:0] is not 2'b00.
- R10: A misaligned read or write raises misalign_o for exactly the following cycle. It does not change memory and gives no rd_valid_o.
- R11: When req_rd_i and req_wr_i are both high, the write is performed and no read response is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_addr_i | input | BYTE_AW | Byte address |
| req_size_i | input | 2 | Access size: 00 byte, 01 halfword, 10/11 word |
| req_wdata_i | input | 32 | Store data, low-aligned |
| req_strb_i | input | 4 | Size-shaped strobe from the core, ignored |
| req_rd_i | input | 1 | Read request |
| req_wr_i | input | 1 | Write request |
| rd_data_o | output | 32 | Lane-shifted, zero-filled read data |
| rd_valid_o | output | 1 | Read data valid, one cycle after the request |
| misalign_o | output | 1 | Misaligned access fault, one cycle after the request |

## Verification
The bench goes after stores at non-zero byte offsets. It pairs them with strobes that are wrong, empty or all-ones. A design that used the strobe as the lane mask would write the wrong lane, or no lane at all, and the word read back would show it.

Byte and halfword reads at every offset expose a port that returns the raw word instead of shifting the addressed lane down. Halfword accesses at offset 2 catch an alignment check that is too strict and would fault a legal access. Misaligned stores followed by a read-back catch a fault that still lets the write through. A request with both read and write high, and a size code of 2'b11, check the less common decode paths.

// File: rtl/lane_mem_pkg.sv
package lane_mem_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANE_N = DATA_W / 8;
  localparam int unsigned OFF_W  = $clog2(LANE_N);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lane_ctl.sv
module lane_ctl
  import lane_mem_pkg::*;
(
  input  acc_size_e         size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [LANE_N-1:0] lane_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              misalign_o
);

  always_comb begin
    case (size_i)
      SZ_BYTE: begin
        lane_o     = LANE_N'(1) << off_i;
        wdata_o    = {LANE_N{wdata_i[7:0]}};
        misalign_o = 1'b0;
      end
      SZ_HALF: begin
        lane_o     = off_i[1] ? 4'b1100 : 4'b0011;
        wdata_o    = {2{wdata_i[15:0]}};
        misalign_o = off_i[0];
      end
      default: begin
        lane_o     = '1;
        wdata_o    = wdata_i;
        misalign_o = |off_i;
      end
    endcase
  end

  always_comb begin
    // R6
    lane_count_chk: assert (misalign_o || $countones(lane_o) ==
      ((size_i == SZ_BYTE) ? 1 : (size_i == SZ_HALF) ? 2 : 4));
    // R8
    half_ofs2_chk: assert (!(size_i == SZ_HALF && off_i == 2'd2 && misalign_o));
  end

endmodule

// File: rtl/lane_ram.sv
module lane_ram
  import lane_mem_pkg::*;
#(
  parameter  int unsigned DEPTH = 1024,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [LANE_N-1:0] lane_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o
);

  // one byte-wide bank per lane, each with its own write enable
  for (genvar g = 0; g < LANE_N; g++) begin : g_lane
    logic [7:0] bank [DEPTH];
    logic [7:0] q;

    always_ff @(posedge clk_i) begin
      if (we_i && lane_i[g]) bank[idx_i] <= wdata_i[8*g +: 8];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q <= '0;
      else if (re_i) q <= bank[idx_i];
    end

    assign rdata_o[8*g +: 8] = q;
  end

endmodule

// File: rtl/rd_align.sv
module rd_align
  import lane_mem_pkg::*;
(
  input  acc_size_e         size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o
);

  always_comb begin
    case (size_i)
      SZ_BYTE: data_o = {24'b0, word_i[{off_i, 3'b000} +: 8]};
      SZ_HALF: data_o = off_i[1] ? {16'b0, word_i[31:16]} : {16'b0, word_i[15:0]};
      default: data_o = word_i;
    endcase
  end

endmodule

// File: rtl/lane_mem_port.sv
module lane_mem_port
  import lane_mem_pkg::*;
#(
  parameter int unsigned BYTE_AW = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [BYTE_AW-1:0] req_addr_i,
  input  logic [1:0]         req_size_i,
  input  logic [31:0]        req_wdata_i,
  input  logic [3:0]         req_strb_i,
  input  logic               req_rd_i,
  input  logic               req_wr_i,
  output logic [31:0]        rd_data_o,
  output logic               rd_valid_o,
  output logic               misalign_o
);

  localparam int unsigned WORD_AW = BYTE_AW - OFF_W;
  localparam int unsigned DEPTH   = 1 << WORD_AW;

  acc_size_e         size_w;
  logic [LANE_N-1:0] lane_w;
  logic [DATA_W-1:0] wrep_w;
  logic [DATA_W-1:0] word_w;
  logic              mis_w;
  logic              we_w;
  logic              re_w;

  acc_size_e         size_q;
  logic [OFF_W-1:0]  off_q;
  logic              valid_q;
  logic              fault_q;

  // strobe is size-shaped and not address-shifted: lanes come from size + addr
  logic unused_strb;
  assign unused_strb = ^req_strb_i;

  assign size_w = acc_size_e'(req_size_i);

  lane_ctl u_ctl (
    .size_i     (size_w),
    .off_i      (req_addr_i[OFF_W-1:0]),
    .wdata_i    (req_wdata_i),
    .lane_o     (lane_w),
    .wdata_o    (wrep_w),
    .misalign_o (mis_w)
  );

  assign we_w = req_wr_i & ~mis_w;
  assign re_w = req_rd_i & ~req_wr_i & ~mis_w;

  lane_ram #(.DEPTH(DEPTH)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_w),
    .lane_i  (lane_w),
    .idx_i   (req_addr_i[BYTE_AW-1:OFF_W]),
    .wdata_i (wrep_w),
    .re_i    (re_w),
    .rdata_o (word_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q  <= SZ_BYTE;
      off_q   <= '0;
      valid_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      valid_q <= re_w;
      fault_q <= (req_rd_i | req_wr_i) & mis_w;
      if (re_w) begin
        size_q <= size_w;
        off_q  <= req_addr_i[OFF_W-1:0];
      end
    end
  end

  rd_align u_align (
    .size_i (size_q),
    .off_i  (off_q),
    .word_i (word_w),
    .data_o (rd_data_o)
  );

  assign rd_valid_o = valid_q;
  assign misalign_o = fault_q;

  // R2
  rd_valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(req_rd_i && !req_wr_i));
  // R10
  fault_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_valid_o && misalign_o));
  // R10
  fault_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> $past(req_rd_i || req_wr_i));
  // R3
  byte_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && $past(req_size_i) == 2'b00) |-> rd_data_o[31:8] == 24'b0);

endmodule

// File: tb/lane_mem_port_tb_top.sv
module lane_mem_port_tb_top;

  typedef struct packed {
    logic [3:0]  req;
    logic        wr;
    logic        rd;
    logic [1:0]  size;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [3:0]  strb;
    logic        ev;
    logic        ef;
    logic [31:0] ed;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    {4'd5,  1'b1,1'b0,2'd2,12'h010,32'hA1B2C3D4,4'hF,1'b0,1'b0,32'h0},        // R5 store
    {4'd5,  1'b0,1'b1,2'd2,12'h010,32'h0,4'h0,1'b1,1'b0,32'hA1B2C3D4},        // R5
    {4'd3,  1'b0,1'b1,2'd0,12'h010,32'h0,4'h0,1'b1,1'b0,32'h000000D4},        // R3
    {4'd3,  1'b0,1'b1,2'd0,12'h011,32'h0,4'h0,1'b1,1'b0,32'h000000C3},        // R3
    {4'd3,  1'b0,1'b1,2'd0,12'h012,32'h0,4'h0,1'b1,1'b0,32'h000000B2},        // R3
    {4'd3,  1'b0,1'b1,2'd0,12'h013,32'h0,4'h0,1'b1,1'b0,32'h000000A1},        // R3
    {4'd2,  1'b0,1'b0,2'd0,12'h000,32'h0,4'h0,1'b0,1'b0,32'h0},               // R2 idle
    {4'd4,  1'b0,1'b1,2'd1,12'h010,32'h0,4'h0,1'b1,1'b0,32'h0000C3D4},        // R4
    {4'd8,  1'b0,1'b1,2'd1,12'h012,32'h0,4'h0,1'b1,1'b0,32'h0000A1B2},        // R8
    {4'd7,  1'b1,1'b0,2'd0,12'h011,32'h0000005E,4'h1,1'b0,1'b0,32'h0},        // R7
    {4'd6,  1'b0,1'b1,2'd2,12'h010,32'h0,4'h0,1'b1,1'b0,32'hA1B25ED4},        // R6
    {4'd8,  1'b1,1'b0,2'd1,12'h012,32'h00007788,4'h3,1'b0,1'b0,32'h0},        // R8
    {4'd6,  1'b0,1'b1,2'd2,12'h010,32'h0,4'h0,1'b1,1'b0,32'h77885ED4},        // R6
    {4'd7,  1'b1,1'b0,2'd0,12'h013,32'hFFFFFF99,4'hF,1'b0,1'b0,32'h0},        // R7
    {4'd7,  1'b0,1'b1,2'd2,12'h010,32'h0,4'h0,1'b1,1'b0,32'h99885ED4},        // R7
    {4'd8,  1'b1,1'b0,2'd1,12'h011,32'h00001234,4'h3,1'b0,1'b1,32'h0},        // R8
    {4'd10, 1'b0,1'b1,2'd2,12'h010,32'h0,4'h0,1'b1,1'b0,32'h99885ED4},        // R10
    {4'd9,  1'b1,1'b0,2'd2,12'h012,32'hDEADBEEF,4'hF,1'b0,1'b1,32'h0},        // R9
    {4'd9,  1'b0,1'b1,2'd2,12'h013,32'h0,4'h0,1'b0,1'b1,32'h0},               // R9
    {4'd9,  1'b1,1'b0,2'd2,12'h011,32'hDEADBEEF,4'hF,1'b0,1'b1,32'h0},        // R9
    {4'd10, 1'b0,1'b1,2'd1,12'h013,32'h0,4'h0,1'b0,1'b1,32'h0},               // R10
    {4'd10, 1'b0,1'b1,2'd2,12'h010,32'h0,4'h0,1'b1,1'b0,32'h99885ED4},        // R10
    {4'd11, 1'b1,1'b1,2'd0,12'h010,32'h00000011,4'h1,1'b0,1'b0,32'h0},        // R11
    {4'd11, 1'b0,1'b1,2'd2,12'h010,32'h0,4'h0,1'b1,1'b0,32'h99885E11},        // R11
    {4'd7,  1'b1,1'b0,2'd2,12'h020,32'hCAFEF00D,4'h0,1'b0,1'b0,32'h0},        // R7
    {4'd7,  1'b0,1'b1,2'd2,12'h020,32'h0,4'h0,1'b1,1'b0,32'hCAFEF00D},        // R7
    {4'd6,  1'b1,1'b0,2'd0,12'h020,32'hAABBCC42,4'h1,1'b0,1'b0,32'h0},        // R6
    {4'd6,  1'b0,1'b1,2'd2,12'h020,32'h0,4'h0,1'b1,1'b0,32'hCAFEF042},        // R6
    {4'd4,  1'b1,1'b0,2'd1,12'h022,32'h5555ABCD,4'h3,1'b0,1'b0,32'h0},        // R4
    {4'd4,  1'b0,1'b1,2'd1,12'h022,32'h0,4'h0,1'b1,1'b0,32'h0000ABCD},        // R4
    {4'd5,  1'b1,1'b0,2'd3,12'h030,32'h12345678,4'h0,1'b0,1'b0,32'h0},        // R5 size 11
    {4'd5,  1'b0,1'b1,2'd3,12'h030,32'h0,4'h0,1'b1,1'b0,32'h12345678},        // R5
    {4'd3,  1'b0,1'b1,2'd0,12'h031,32'h0,4'h0,1'b1,1'b0,32'h00000056}         // R3
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] req_addr_i = '0;
  logic [1:0]  req_size_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic [3:0]  req_strb_i = '0;
  logic        req_rd_i = 1'b0;
  logic        req_wr_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        rd_valid_o;
  logic        misalign_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  lane_mem_port #(.BYTE_AW(12)) dut_i (
    .clk_i, .rst_ni, .req_addr_i, .req_size_i, .req_wdata_i, .req_strb_i,
    .req_rd_i, .req_wr_i, .rd_data_o, .rd_valid_o, .misalign_o
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_addr_i  = v.addr;
    req_size_i  = v.size;
    req_wdata_i = v.wdata;
    req_strb_i  = v.strb;
    req_rd_i    = v.rd;
    req_wr_i    = v.wr;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R0 watchdog act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 state held in reset
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1", "valid", 32'(rd_valid_o), 32'h0);
    chk("R1", "fault", 32'(misalign_o), 32'h0);
    chk("R1", "data", rd_data_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(VECS[i]);
      @(posedge clk_i);
      #1;
      chk($sformatf("R%0d", VECS[i].req), $sformatf("v%0d valid", i),
          32'(rd_valid_o), 32'(VECS[i].ev));
      chk($sformatf("R%0d", VECS[i].req), $sformatf("v%0d fault", i),
          32'(misalign_o), 32'(VECS[i].ef));
      if (VECS[i].ev)
        chk($sformatf("R%0d", VECS[i].req), $sformatf("v%0d data", i),
            rd_data_o, VECS[i].ed);
    end

    // R10 fault lasts one cycle: misaligned word read, then idle
    @(negedge clk_i);
    drive('{req:4'd10, wr:1'b0, rd:1'b1, size:2'd2, addr:12'h012,
            wdata:32'h0, strb:4'h0, ev:1'b0, ef:1'b1, ed:32'h0});
    @(posedge clk_i);
    #1;
    chk("R10", "pulse high", 32'(misalign_o), 32'h1);
    @(negedge clk_i);
    req_rd_i = 1'b0;
    @(posedge clk_i);
    #1;
    chk("R10", "pulse low", 32'(misalign_o), 32'h0);
    chk("R2", "idle valid", 32'(rd_valid_o), 32'h0);

    // R1 reset mid-run clears a pending read response
    @(negedge clk_i);
    req_rd_i = 1'b1;
    req_size_i = 2'd2;
    req_addr_i = 12'h010;
    @(posedge clk_i);
    #1;
    chk("R2", "pre-reset valid", 32'(rd_valid_o), 32'h1);
    @(negedge clk_i);
    req_rd_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk("R1", "mid valid", 32'(rd_valid_o), 32'h0);
    chk("R1", "mid data", rd_data_o, 32'h0);
    chk("R1", "mid fault", 32'(misalign_o), 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule